// File: doc/BRIEF.md
# Serially Fed Four-Word Display Register Bank

This block is the receiving end of a narrow link that fills four display words one bit at a time. The sender drives four wires: a serial data bit, a two-bit word address and a shift strobe. An address decoder turns the strobe and address into a shift enable for exactly one of the four word registers. On each rising clock edge with the strobe high, that register moves its contents one place toward bit 0 and takes the serial bit into its top bit. The other three registers keep their contents.

A separate two-bit view select picks one of the four stored words and shows it on the eight-bit output through a combinational 4-to-1 selector. To send a full word, the sender holds the address steady and raises the strobe for eight consecutive clocks, sending the least significant bit first. Once the eighth bit is in, the register holds the word exactly as it was sent. A synchronous active-high reset clears every register.

Top module: `serial_display_bank`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) sets all four words to 0x00. After that edge, view_data reads 0x00 for every view_sel value.
- R2: While link_shift is high, only the word whose index equals link_addr (0 to 3) changes at the clock edge. The other three words keep their values.
- R3: A shift moves every bit of the addressed word one position toward bit 0, drops the old bit 0 and writes link_bit into bit 7.
- R4: Eight consecutive shifts to one address, with the bits sent in the order bit 0 first through bit 7 last, leave that word equal to the byte that was sent.
- R5: While link_shift is low, no word changes, whatever link_addr and link_bit are.
- R6: view_data equals the word whose index is view_sel (0 to 3). It follows a change of view_sel with no clock edge in between.
- R7: A shift shows on view_data right after the clock edge that performs it, with no added register stage.
- R8: Reset takes priority over a shift in the same cycle. If rst and link_shift are both high, every word is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| link_bit | input | 1 | Serial data bit taken into the addressed word |
| link_addr | input | 2 | Index of the word the strobe acts on |
| link_shift | input | 1 | Shift strobe: high shifts the addressed word this cycle |
| view_sel | input | 2 | Index of the word shown on view_data |
| view_data | output | 8 | Selected stored word |

## Verification
The assertions assume that link_addr and view_sel only carry indices below the word count, which always holds for the default four words. They also assume that the link inputs settle well before each rising edge. The stimulus changes every input one nanosecond after an edge. It only ever uses addresses 0 to 3, so every strobe has exactly one target. Reset is raised both with and without the strobe, so the clearing properties are exercised with the hold and shift paths active at the same time.

// File: rtl/sdb_pkg.sv
package sdb_pkg;

    localparam int unsigned DEF_WORD_W   = 8;
    localparam int unsigned DEF_NUM_REGS = 4;

    typedef enum logic [1:0] {
        CELL_HOLD  = 2'd0,
        CELL_SHIFT = 2'd1,
        CELL_CLEAR = 2'd2
    } cell_op_e;

    function automatic cell_op_e pick_op(input logic clear, input logic shift);
        if (clear)      return CELL_CLEAR;
        else if (shift) return CELL_SHIFT;
        else            return CELL_HOLD;
    endfunction

endpackage

// File: rtl/sdb_addr_decoder.sv
module sdb_addr_decoder #(
    parameter int unsigned NUM_REGS = sdb_pkg::DEF_NUM_REGS,
    parameter int unsigned ADDR_W   = 2
) (
    input  logic                strobe,
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] enable
);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
        assign enable[i] = strobe && (addr == ADDR_W'(i));
    end

endmodule

// File: rtl/sdb_shift_cell.sv
module sdb_shift_cell
    import sdb_pkg::*;
#(
    parameter int unsigned WORD_W = sdb_pkg::DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              ser_in,
    output logic [WORD_W-1:0] word_q
);

    cell_op_e op;

    always_comb begin
        op = pick_op(rst, shift_en);
    end

    always_ff @(posedge clk) begin
        case (op)
            CELL_CLEAR: word_q <= '0;
            CELL_SHIFT: word_q <= {ser_in, word_q[WORD_W-1:1]};
            default:    word_q <= word_q;
        endcase
    end

    // R3: lower bits take the previous upper bits after an enabled edge
    p_shift_moves_r3: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (word_q[WORD_W-2:0] == $past(word_q[WORD_W-1:1])));

    // R3: the serial bit lands in the top position
    p_top_bit_r3: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (word_q[WORD_W-1] == $past(ser_in)));

    // R8: reset clears even when a shift is requested
    p_clear_wins_r8: assert property (@(posedge clk)
        (rst && shift_en) |=> (word_q == '0));

endmodule

// File: rtl/sdb_view_mux.sv
module sdb_view_mux #(
    parameter int unsigned WORD_W   = sdb_pkg::DEF_WORD_W,
    parameter int unsigned NUM_REGS = sdb_pkg::DEF_NUM_REGS,
    parameter int unsigned SEL_W    = 2
) (
    input  logic [NUM_REGS-1:0][WORD_W-1:0] words,
    input  logic [SEL_W-1:0]                sel,
    output logic [WORD_W-1:0]               out_word
);

    always_comb begin
        out_word = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (sel == SEL_W'(i)) out_word = words[i];
        end
    end

endmodule

// File: rtl/serial_display_bank.sv
module serial_display_bank #(
    parameter int unsigned WORD_W   = sdb_pkg::DEF_WORD_W,
    parameter int unsigned NUM_REGS = sdb_pkg::DEF_NUM_REGS,
    localparam int unsigned SEL_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              link_bit,
    input  logic [SEL_W-1:0]  link_addr,
    input  logic              link_shift,
    input  logic [SEL_W-1:0]  view_sel,
    output logic [WORD_W-1:0] view_data
);

    logic [NUM_REGS-1:0]             shift_en;
    logic [NUM_REGS-1:0][WORD_W-1:0] words;

    sdb_addr_decoder #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (SEL_W)
    ) u_dec (
        .strobe (link_shift),
        .addr   (link_addr),
        .enable (shift_en)
    );

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
        sdb_shift_cell #(
            .WORD_W (WORD_W)
        ) u_cell (
            .clk      (clk),
            .rst      (rst),
            .shift_en (shift_en[i]),
            .ser_in   (link_bit),
            .word_q   (words[i])
        );

        // R2: a word not addressed by an active strobe keeps its value
        p_unaddressed_hold_r2: assert property (@(posedge clk) disable iff (rst)
            !(link_shift && (link_addr == SEL_W'(i))) |=> $stable(words[i]));

        // R5: with the strobe low no word moves
        p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
            !link_shift |=> $stable(words[i]));

        // R1: reset leaves every word at zero
        p_reset_clear_r1: assert property (@(posedge clk)
            rst |=> (words[i] == '0));
    end

    // R2: the decoder never enables more than one word
    p_single_target_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(shift_en));

    // R2: an active strobe always reaches exactly one word
    p_strobe_hits_r2: assert property (@(posedge clk) disable iff (rst)
        link_shift |-> ($countones(shift_en) == 1));

    sdb_view_mux #(
        .WORD_W   (WORD_W),
        .NUM_REGS (NUM_REGS),
        .SEL_W    (SEL_W)
    ) u_mux (
        .words    (words),
        .sel      (view_sel),
        .out_word (view_data)
    );

endmodule

// File: tb/sim_serial_display_bank.sv
`timescale 1ns/100ps
module sim_serial_display_bank;

    logic       clk = 1'b0;
    logic       rst;
    logic       link_bit;
    logic [1:0] link_addr;
    logic       link_shift;
    logic [1:0] view_sel;
    logic [7:0] view_data;

    int total  = 0;
    int failed = 0;
    logic [7:0] model [4];

    always #2.5 clk = ~clk;

    serial_display_bank u0 (
        .clk        (clk),
        .rst        (rst),
        .link_bit   (link_bit),
        .link_addr  (link_addr),
        .link_shift (link_shift),
        .view_sel   (view_sel),
        .view_data  (view_data)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // reads every word through the selector; called about 1 ns after an edge
    task automatic read_all(input int tgt, input string t_tag, input string o_tag);
        for (int s = 0; s < 4; s++) begin
            view_sel = 2'(s);
            #0.5;
            check((s == tgt) ? t_tag : o_tag, view_data, model[s]);
        end
    endtask

    task automatic step(input logic r, input logic sh, input logic [1:0] a, input logic b);
        rst = r; link_shift = sh; link_addr = a; link_bit = b;
        @(posedge clk);
        #1;
    endtask

    task automatic clear_model();
        for (int i = 0; i < 4; i++) model[i] = 8'h00;
    endtask

    task automatic send_byte(input logic [1:0] a, input logic [7:0] v);
        for (int k = 0; k < 8; k++) step(1'b0, 1'b1, a, v[k]);
        model[a] = v;
        step(1'b0, 1'b0, a, 1'b0);
    endtask

    initial begin
        #(200000 * 5);
        failed++;
        total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        rst = 1'b1; link_shift = 1'b0; link_addr = 2'd0; link_bit = 1'b0; view_sel = 2'd0;
        @(posedge clk); #1;
        step(1'b1, 1'b0, 2'd0, 1'b0);
        clear_model();
        read_all(-1, "R1", "R1");

        // R4 / R2: every byte value into every word, others must hold
        for (int a = 0; a < 4; a++) begin
            for (int v = 0; v < 256; v++) begin
                send_byte(2'(a), 8'(v));
                read_all(a, "R4", "R2");
            end
        end

        // R3 / R7: single shifts checked bit by bit right after the edge
        step(1'b1, 1'b0, 2'd0, 1'b0);
        clear_model();
        begin
            logic [7:0] pat;
            logic [7:0] exp;
            pat = 8'b1011_0110;
            exp = 8'h00;
            for (int k = 0; k < 8; k++) begin
                step(1'b0, 1'b1, 2'd2, pat[k]);
                exp = (exp >> 1) | (8'(pat[k]) << 7);
                model[2] = exp;
                view_sel = 2'd2;
                #0.5;
                check("R7", view_data, exp);
                read_all(2, "R3", "R2");
            end
        end

        // R6: distinct words, selector swept in scrambled order
        send_byte(2'd0, 8'hA1);
        send_byte(2'd1, 8'h3C);
        send_byte(2'd2, 8'hE7);
        send_byte(2'd3, 8'h58);
        for (int n = 0; n < 8; n++) begin
            int s;
            s = (n * 3 + 1) % 4;
            view_sel = 2'(s);
            #0.5;
            check("R6", view_data, model[s]);
        end

        // R5: strobe low with every address and bit value
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 2; b++) begin
                step(1'b0, 1'b0, 2'(a), 1'(b));
                read_all(-1, "R5", "R5");
            end
        end

        // R8: reset together with a shift clears everything
        step(1'b1, 1'b1, 2'd1, 1'b1);
        clear_model();
        read_all(-1, "R8", "R8");
        step(1'b0, 1'b0, 2'd0, 1'b0);
        read_all(-1, "R1", "R1");

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule